// File: doc/BRIEF.md
# Torus Row-Column Sum Reducer

This block is the reduction engine of one node in a square two-dimensional torus of K by K nodes. Every node holds an identical copy. Together they compute the sum of all values in the array, and each node ends with that sum.

A node starts by accumulating a stream of local words into its own total. It then runs a ring pass along its row, sending to the left neighbour and receiving from the right one. After that it runs a second ring pass along its column, sending upward and receiving from below. The column pass starts from the row total.

Each ring pass has exactly K steps, so a node makes 2*K transfers in each direction. In every step the node sends one word and receives one word over separate valid/ready channels. The step is over only when both transfers have completed.

The first word a node sends in a pass is its own starting value. After that it forwards the word it received in the step before. The words received in the first K-1 steps are added to the total. The word received in the K-th step is the node's own starting value coming back around the ring, and it is not added.

Top module: `torus_sum_node`

## Requirements
- R1: After reset, and after any reset in the middle of a run, `done`, `ovf`, `loc_ready`, every transmit valid and every receive ready are 0, and `result` is 0.
- R2: `loc_ready` is 1 only between an accepted `start` and the accepted beat with `loc_last` = 1. The local total is the sum of every accepted beat, including the last one. No transmit valid is raised while `loc_ready` is 1.
- R3: In the row pass the node makes exactly K transfers on the row send port. The first word sent is the local total. Each later word sent equals the word received on the row receive port in the step before.
- R4: In a step, once the send transfer has completed, the send valid stays 0 until the receive transfer of that step has also completed. The next step starts only after both transfers are done.
- R5: The row total is the local total plus the words received in the first K-1 row steps. The word received in step K is discarded.
- R6: After the row pass the node runs K column steps under the same rules as R3, R4 and R5. The first word sent upward is the row total.
- R7: `done` is 1 for exactly one cycle after the last column step. During that cycle `result` holds the global sum: the row total plus the first K-1 column words received. `result` keeps that value afterwards.
- R8: All sums wrap modulo 2^W. `ovf` is set when any addition carries out of W bits. Those additions are each accumulated local beat and each ring word that is added. `ovf` stays set until the next accepted `start` clears it.
- R9: `start` is ignored while a reduction is in progress. A pulse during the local stream neither clears the local total nor changes the result.
- R10: The row and column ports are never active together. During the column pass, no row send valid is raised.
- R11: A send valid stays 1, with its data unchanged, until the neighbour accepts it. A receive ready stays 1 until a word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reduction (accepted only when idle) |
| loc_valid | input | 1 | Local data word valid |
| loc_data | input | W | Local data word |
| loc_last | input | 1 | Marks the final local word |
| loc_ready | output | 1 | Node accepts local data |
| row_tx_valid | output | 1 | Word to left neighbour valid |
| row_tx_data | output | W | Word to left neighbour |
| row_tx_ready | input | 1 | Left neighbour accepts |
| row_rx_valid | input | 1 | Word from right neighbour valid |
| row_rx_data | input | W | Word from right neighbour |
| row_rx_ready | output | 1 | Node accepts word from right |
| col_tx_valid | output | 1 | Word to upward neighbour valid |
| col_tx_data | output | W | Word to upward neighbour |
| col_tx_ready | input | 1 | Upward neighbour accepts |
| col_rx_valid | input | 1 | Word from lower neighbour valid |
| col_rx_data | input | W | Word from lower neighbour |
| col_rx_ready | output | 1 | Node accepts word from below |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Global sum |
| ovf | output | 1 | Sticky carry-out flag |

## Verification
The handshake assertions assume that the neighbours obey valid/ready: a word is offered on a receive port only during a ring step of the matching dimension, and a neighbour never withdraws what it has offered. The bench plays every neighbour. It holds each receive word steady until the node takes it, raises its ready signals only after per-case delays, and offers no word to a dimension that is idle. Local beats are presented only in the local phase. The one deliberate breach is a `start` pulse during streaming, which the block must ignore.

// File: rtl/torus_sum_pkg.sv
package torus_sum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCAL,
        ST_ROW,
        ST_COL,
        ST_DONE
    } phase_e;

    localparam int DIM_ROW  = 0;
    localparam int DIM_COL  = 1;
    localparam int NUM_DIMS = 2;

    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tsr_local_acc.sv
module tsr_local_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         fire,
    input  logic [W-1:0] data,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W:0] ext;

    assign ext = {1'b0, sum} + {1'b0, data};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum <= '0;
            ovf <= 1'b0;
        end else if (fire) begin
            sum <= ext[W-1:0];
            ovf <= ovf | ext[W];
        end
    end
endmodule

// File: rtl/tsr_ring_port.sv
module tsr_ring_port #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_go,
    input  logic [W-1:0] send_val,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    input  logic         tx_ready,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    output logic         rx_ready,
    output logic         step_done,
    output logic [W-1:0] recv_val
);
    logic busy, tx_pend, rx_pend, done_q;
    logic [W-1:0] tx_q, recv_q;
    logic tx_fire, rx_fire, tx_fin, rx_fin;

    assign tx_fire = tx_pend && tx_ready;
    assign rx_fire = rx_pend && rx_valid;
    assign tx_fin  = !tx_pend || tx_fire;
    assign rx_fin  = !rx_pend || rx_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            tx_pend <= 1'b0;
            rx_pend <= 1'b0;
            done_q  <= 1'b0;
            tx_q    <= '0;
            recv_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (step_go) begin
                busy    <= 1'b1;
                tx_pend <= 1'b1;
                rx_pend <= 1'b1;
                tx_q    <= send_val;
            end else if (busy) begin
                if (tx_fire) tx_pend <= 1'b0;
                if (rx_fire) begin
                    rx_pend <= 1'b0;
                    recv_q  <= rx_data;
                end
                if (tx_fin && rx_fin) begin
                    busy   <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign tx_valid  = tx_pend;
    assign tx_data   = tx_q;
    assign rx_ready  = rx_pend;
    assign step_done = done_q;
    assign recv_val  = recv_q;
endmodule

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
    import torus_sum_pkg::*;
#(
    parameter int W = 32,
    parameter int K = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         loc_valid,
    input  logic                         loc_last,
    input  logic [W-1:0]                 loc_sum,
    input  logic [NUM_DIMS-1:0]          step_done,
    input  logic [NUM_DIMS-1:0][W-1:0]   recv,
    output logic                         loc_ready,
    output logic                         clear_loc,
    output logic [NUM_DIMS-1:0]          go,
    output logic [W-1:0]                 send_val,
    output logic                         done,
    output logic [W-1:0]                 result,
    output logic                         ring_ovf
);
    localparam int CW = cnt_bits(K);
    localparam logic [CW-1:0] LAST_STEP = CW'(K - 1);

    phase_e         st;
    logic [CW-1:0]  cnt;
    logic           go_pend;
    logic [W-1:0]   acc, fwd, result_q, rcv;
    logic           in_ring, dim, sdone;
    logic [W:0]     ring_ext;

    assign in_ring  = (st == ST_ROW) || (st == ST_COL);
    assign dim      = (st == ST_COL);
    assign sdone    = in_ring && step_done[dim];
    assign rcv      = recv[dim];
    assign ring_ext = {1'b0, acc} + {1'b0, rcv};

    always_comb begin
        go = '0;
        if (in_ring && go_pend) go[dim] = 1'b1;
        if (cnt == '0) send_val = (st == ST_ROW) ? loc_sum : acc;
        else           send_val = fwd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            go_pend  <= 1'b0;
            acc      <= '0;
            fwd      <= '0;
            ring_ovf <= 1'b0;
            result_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st       <= ST_LOCAL;
                    ring_ovf <= 1'b0;
                end
                ST_LOCAL: if (loc_valid && loc_last) begin
                    st      <= ST_ROW;
                    go_pend <= 1'b1;
                    cnt     <= '0;
                end
                ST_ROW, ST_COL: begin
                    if (go_pend) begin
                        go_pend <= 1'b0;
                        if (st == ST_ROW && cnt == '0) acc <= loc_sum;
                    end
                    if (sdone) begin
                        if (cnt != LAST_STEP) begin
                            acc      <= ring_ext[W-1:0];
                            ring_ovf <= ring_ovf | ring_ext[W];
                            fwd      <= rcv;
                            cnt      <= cnt + 1'b1;
                            go_pend  <= 1'b1;
                        end else begin
                            cnt <= '0;
                            if (st == ST_ROW) begin
                                st      <= ST_COL;
                                go_pend <= 1'b1;
                            end else begin
                                st       <= ST_DONE;
                                result_q <= acc;
                            end
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign loc_ready = (st == ST_LOCAL);
    assign clear_loc = (st == ST_IDLE) && start;
    assign done      = (st == ST_DONE);
    assign result    = result_q;
endmodule

// File: rtl/torus_sum_node.sv
module torus_sum_node
    import torus_sum_pkg::*;
#(
    parameter int W = 32,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         loc_valid,
    input  logic [W-1:0] loc_data,
    input  logic         loc_last,
    output logic         loc_ready,
    output logic         row_tx_valid,
    output logic [W-1:0] row_tx_data,
    input  logic         row_tx_ready,
    input  logic         row_rx_valid,
    input  logic [W-1:0] row_rx_data,
    output logic         row_rx_ready,
    output logic         col_tx_valid,
    output logic [W-1:0] col_tx_data,
    input  logic         col_tx_ready,
    input  logic         col_rx_valid,
    input  logic [W-1:0] col_rx_data,
    output logic         col_rx_ready,
    output logic         done,
    output logic [W-1:0] result,
    output logic         ovf
);
    logic                       clear_loc, loc_fire, loc_ovf, ring_ovf;
    logic [W-1:0]               loc_sum, send_val;
    logic [NUM_DIMS-1:0]        go, step_done;
    logic [NUM_DIMS-1:0][W-1:0] recv;
    logic [NUM_DIMS-1:0]        txv, txr, rxv, rxr;
    logic [NUM_DIMS-1:0][W-1:0] txd, rxd;

    assign loc_fire = loc_valid && loc_ready;

    assign txr[DIM_ROW] = row_tx_ready;
    assign txr[DIM_COL] = col_tx_ready;
    assign rxv[DIM_ROW] = row_rx_valid;
    assign rxv[DIM_COL] = col_rx_valid;
    assign rxd[DIM_ROW] = row_rx_data;
    assign rxd[DIM_COL] = col_rx_data;

    tsr_local_acc #(.W(W)) u_local (
        .clk   (clk),
        .rst   (rst),
        .clear (clear_loc),
        .fire  (loc_fire),
        .data  (loc_data),
        .sum   (loc_sum),
        .ovf   (loc_ovf)
    );

    tsr_ctrl #(.W(W), .K(K)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .loc_valid (loc_valid),
        .loc_last  (loc_last),
        .loc_sum   (loc_sum),
        .step_done (step_done),
        .recv      (recv),
        .loc_ready (loc_ready),
        .clear_loc (clear_loc),
        .go        (go),
        .send_val  (send_val),
        .done      (done),
        .result    (result),
        .ring_ovf  (ring_ovf)
    );

    for (genvar d = 0; d < NUM_DIMS; d++) begin : g_port
        tsr_ring_port #(.W(W)) u_port (
            .clk       (clk),
            .rst       (rst),
            .step_go   (go[d]),
            .send_val  (send_val),
            .tx_valid  (txv[d]),
            .tx_data   (txd[d]),
            .tx_ready  (txr[d]),
            .rx_valid  (rxv[d]),
            .rx_data   (rxd[d]),
            .rx_ready  (rxr[d]),
            .step_done (step_done[d]),
            .recv_val  (recv[d])
        );
    end

    assign row_tx_valid = txv[DIM_ROW];
    assign row_tx_data  = txd[DIM_ROW];
    assign row_rx_ready = rxr[DIM_ROW];
    assign col_tx_valid = txv[DIM_COL];
    assign col_tx_data  = txd[DIM_COL];
    assign col_rx_ready = rxr[DIM_COL];
    assign ovf          = loc_ovf | ring_ovf;
endmodule

// File: rtl/torus_sum_node_chk.sv
module torus_sum_node_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         loc_ready,
    input logic         row_tx_valid,
    input logic [W-1:0] row_tx_data,
    input logic         row_tx_ready,
    input logic         row_rx_valid,
    input logic         row_rx_ready,
    input logic         col_tx_valid,
    input logic [W-1:0] col_tx_data,
    input logic         col_tx_ready,
    input logic         col_rx_valid,
    input logic         col_rx_ready,
    input logic         done,
    input logic [W-1:0] result
);
    AST_ROW_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        row_tx_valid && !row_tx_ready |=> row_tx_valid && $stable(row_tx_data)); // R11
    AST_COL_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        col_tx_valid && !col_tx_ready |=> col_tx_valid && $stable(col_tx_data)); // R11
    AST_ROW_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        row_rx_ready && !row_rx_valid |=> row_rx_ready); // R11
    AST_COL_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        col_rx_ready && !col_rx_valid |=> col_rx_ready); // R11
    AST_ONE_DIM: assert property (@(posedge clk) disable iff (rst)
        !((row_tx_valid || row_rx_ready) && (col_tx_valid || col_rx_ready))); // R10
    AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        loc_ready |-> !row_tx_valid && !col_tx_valid); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(result)); // R7
    AST_TX_WAITS_RX: assert property (@(posedge clk) disable iff (rst)
        $fell(row_tx_valid) && row_rx_ready |=> !row_tx_valid); // R4
endmodule

bind torus_sum_node torus_sum_node_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .loc_ready    (loc_ready),
    .row_tx_valid (row_tx_valid),
    .row_tx_data  (row_tx_data),
    .row_tx_ready (row_tx_ready),
    .row_rx_valid (row_rx_valid),
    .row_rx_ready (row_rx_ready),
    .col_tx_valid (col_tx_valid),
    .col_tx_data  (col_tx_data),
    .col_tx_ready (col_tx_ready),
    .col_rx_valid (col_rx_valid),
    .col_rx_ready (col_rx_ready),
    .done         (done),
    .result       (result)
);

// File: tb/torus_sum_node_bench.sv
`timescale 1ns/1ps
module torus_sum_node_bench;
    localparam int W = 32;
    localparam int K = 4;
    localparam int NCASE = 4;
    localparam int CASE_BEATS [NCASE] = '{3, 1, 5, 2};
    localparam int CASE_TXD   [NCASE] = '{0, 2, 0, 3};
    localparam int CASE_RXD   [NCASE] = '{0, 0, 3, 1};

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic loc_valid = 1'b0, loc_last = 1'b0;
    logic [W-1:0] loc_data = '0;
    logic [1:0] tb_txr = '0, tb_rxv = '0;
    logic [W-1:0] tb_rxd [2];
    logic loc_ready, done, ovf;
    logic [W-1:0] result;
    logic [1:0] dtv, drr;
    logic [W-1:0] dtd [2];
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    torus_sum_node #(.W(W), .K(K)) u_torus_sum_node (
        .clk(clk), .rst(rst), .start(start),
        .loc_valid(loc_valid), .loc_data(loc_data), .loc_last(loc_last), .loc_ready(loc_ready),
        .row_tx_valid(dtv[0]), .row_tx_data(dtd[0]), .row_tx_ready(tb_txr[0]),
        .row_rx_valid(tb_rxv[0]), .row_rx_data(tb_rxd[0]), .row_rx_ready(drr[0]),
        .col_tx_valid(dtv[1]), .col_tx_data(dtd[1]), .col_tx_ready(tb_txr[1]),
        .col_rx_valid(tb_rxv[1]), .col_rx_data(tb_rxd[1]), .col_rx_ready(drr[1]),
        .done(done), .result(result), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [W-1:0] beat_val(input int c, input int b);
        return (c == 3) ? (32'hC000_0000 + W'(b)) : W'(c * 7 + b * 3 + 1);
    endfunction
    function automatic logic [W-1:0] row_peer(input int c, input int s);
        return (c == 3) ? (32'h9000_0000 + W'(s)) : W'(c * 100 + s);
    endfunction
    function automatic logic [W-1:0] col_peer(input int c, input int s);
        return (c == 3) ? (32'h8000_0000 + W'(s)) : W'(c * 1000 + s * 11);
    endfunction

    task automatic add_exp(inout logic [W-1:0] acc, inout bit carry, input logic [W-1:0] v);
        logic [W:0] e;
        e = {1'b0, acc} + {1'b0, v};
        acc = e[W-1:0];
        carry = carry | e[W];
    endtask

    // Play the neighbours of one dimension for K steps; checks R3/R4/R6/R10.
    task automatic run_phase(input int dim, input logic [W-1:0] first_tx,
                             input logic [W-1:0] vals [K], input int txd, input int rxd);
        logic [W-1:0] prev;
        string rq;
        prev = first_tx;
        rq = (dim == 0) ? "R3" : "R6";
        for (int s = 0; s < K; s++) begin
            int c = 0;
            bit tx_got = 0, rx_got = 0, gap_bad = 0, other_bad = 0;
            logic [W-1:0] tx_seen = '0;
            while (!dtv[dim] && c < 50) begin @(negedge clk); c++; end
            chk(dtv[dim], rq, "step send valid", W'(dtv[dim]), 1);
            c = 0;
            while (!(tx_got && rx_got) && c < 100) begin
                bit tx_now = 0, rx_now = 0;
                tb_txr[dim] = !tx_got && (c >= txd);
                tb_rxv[dim] = !rx_got && (c >= rxd);
                tb_rxd[dim] = vals[s];
                #1;
                if (dtv[1-dim] || drr[1-dim]) other_bad = 1;
                if (tx_got && dtv[dim]) gap_bad = 1;
                if (dtv[dim] && tb_txr[dim]) begin tx_now = 1; tx_seen = dtd[dim]; end
                if (tb_rxv[dim] && drr[dim]) rx_now = 1;
                @(negedge clk);
                c++;
                tx_got = tx_got | tx_now;
                rx_got = rx_got | rx_now;
            end
            tb_txr[dim] = 1'b0;
            tb_rxv[dim] = 1'b0;
            chk(tx_seen == prev, rq, (s == 0) ? "first sent word" : "forwarded word", tx_seen, prev);
            chk(!gap_bad, "R4", "send idle until receive done", W'(gap_bad), 0);
            chk(!other_bad, "R10", "other dimension idle", W'(other_bad), 0);
            prev = vals[s];
        end
    endtask

    task automatic stream_local(input int c, input bit poke_start,
                                output logic [W-1:0] lsum, output bit carry);
        lsum = '0;
        carry = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int b = 0; b < CASE_BEATS[c]; b++) begin
            bit took = 0;
            int g = 0;
            while (!took && g < 50) begin
                loc_valid = 1'b1;
                loc_data = beat_val(c, b);
                loc_last = (b == CASE_BEATS[c] - 1);
                start = poke_start && (b == 1);
                #1;
                took = loc_ready;
                @(negedge clk);
                g++;
            end
            start = 1'b0;
            chk(took, "R2", "local beat accepted", W'(took), 1);
            add_exp(lsum, carry, beat_val(c, b));
        end
        loc_valid = 1'b0;
        loc_last = 1'b0;
        #1;
        chk(!loc_ready, "R2", "loc_ready drops after last beat", W'(loc_ready), 0);
    endtask

    task automatic run_case(input int c);
        logic [W-1:0] lsum, rsum, gsum, rv [K], cv [K];
        bit carry, seen;
        stream_local(c, c == 2, lsum, carry);
        rsum = lsum;
        for (int s = 0; s < K; s++) begin
            rv[s] = (s < K - 1) ? row_peer(c, s + 1) : lsum;
            if (s < K - 1) add_exp(rsum, carry, rv[s]);
        end
        gsum = rsum;
        for (int s = 0; s < K; s++) begin
            cv[s] = (s < K - 1) ? col_peer(c, s + 1) : rsum;
            if (s < K - 1) add_exp(gsum, carry, cv[s]);
        end
        run_phase(0, lsum, rv, CASE_TXD[c], CASE_RXD[c]);
        run_phase(1, rsum, cv, CASE_TXD[c], CASE_RXD[c]);
        seen = 0;
        for (int g = 0; g < 20 && !seen; g++) begin
            #1;
            if (done) seen = 1; else @(negedge clk);
        end
        chk(seen, "R7", "done pulse", W'(seen), 1);
        chk(result == gsum, (c == 2) ? "R9" : "R5", "global sum", result, gsum);
        chk(ovf == carry, "R8", "carry flag", W'(ovf), W'(carry));
        @(negedge clk); #1;
        chk(!done, "R7", "done lasts one cycle", W'(done), 0);
        chk(result == gsum, "R7", "result held", result, gsum);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tb_rxd[0] = '0;
        tb_rxd[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!done && !ovf && !loc_ready && dtv == 2'b00 && drr == 2'b00, "R1",
            "reset outputs", {done, ovf, loc_ready, dtv, drr}, 0);
        chk(result == '0, "R1", "reset result", result, 0);
        for (int c = 0; c < NCASE; c++) run_case(c);
        // After the overflow case, a clean case must clear the sticky flag (R8).
        run_case(0);
        // Reset in mid-run: abandon the row pass (R1).
        begin
            logic [W-1:0] ls;
            bit cy;
            stream_local(1, 0, ls, cy);
            while (!dtv[0]) @(negedge clk);
            rst = 1'b1;
            @(negedge clk); @(negedge clk);
            rst = 1'b0;
            #1;
            chk(!done && !ovf && !loc_ready && dtv == 2'b00 && drr == 2'b00, "R1",
                "mid-run reset outputs", {done, ovf, loc_ready, dtv, drr}, 0);
            chk(result == '0, "R1", "mid-run reset result", result, 0);
            @(negedge clk);
        end
        run_case(1);
        finish_run();
    end
endmodule